// File: doc/BRIEF.md
# PoE Port Fault Supervisor

This block supervises a single Power-over-Ethernet supply port. Its inputs are digital comparator flags: sense pin too high, gate pin too high, port reads as powered, and port current below the maintain level. It decides when the port is enabled. It recognises a failed pass transistor ("FET Bad") only after a symptom has persisted longer than a set number of microsecond ticks. It also recognises a startup timeout on a turn-on that never comes up, and a powered device that has stopped drawing its minimum current long enough to count as gone.

Each fault shuts the port down in its own way. FET Bad latches until a port reset or a chip reset, forces the port off and selects the weak gate pull-down. A startup fault or a disconnect only switches the port off. All three faults land in a sticky three-bit event register that the host clears with a read strobe. Each new event raises a one-cycle interrupt pulse. A readback-valid flag tells the converter logic when voltage and current samples mean anything.

The chip reset is asynchronous and active low. Internally it is released through a two-stage synchronizer, so the block acts on its inputs from the third rising clock edge after reset release.

Top module: `poe_port_supervisor`

## Requirements
- R1: While reset is asserted, and after it is released, `port_en`, `fet_bad`, `gate_pd_weak`, `irq`, `data_valid` and all bits of `evt` are 0.
- R2: A cycle with `on_req` high enables the port from the next cycle, unless FET Bad is latched or a shutdown condition occurs in the same cycle. A cycle with `off_req` high disables it from the next cycle. `off_req` wins over `on_req`.
- R3: A symptom is `sense_high`, `gate_high`, or `port_on_sense` high while `port_en` is low. FET Bad is declared on the (PERSIST+1)-th consecutive cycle that has `tick_us` high and a symptom present, and never earlier. Cycles with `tick_us` low and a symptom present hold the count.
- R4: From the cycle after the declaration, `fet_bad`=1, `gate_pd_weak`=1, `port_en`=0 and `evt[0]`=1. While `fet_bad` is set, `on_req` is ignored.
- R5: `fet_bad` stays set until `port_rst` (cleared in the next cycle) or chip reset. If the symptom is still present after `port_rst`, FET Bad is declared again after the same persistence count.
- R6: Any cycle without a symptom returns the persistence count to zero.
- R7: If `port_en`=1, `port_on_sense`=0 and `start_tmo`=1 in the same cycle, the port turns off and `evt[1]` is set in the next cycle. An open transistor (port never reads on) never raises FET Bad.
- R8: While `port_en` and `port_on_sense` are both high, a disconnect counter advances on each `tick_us` with `cur_low` high. On the LIMIT-th such tick the port turns off and `evt[2]` is set in the next cycle.
- R9: Any cycle with `cur_low` low, or with the port not powered, resets the disconnect counter to zero.
- R10: Event bits are sticky. `evt_clr` zeroes them in the next cycle, but a bit newly set in the same cycle as `evt_clr` stays set. `port_rst` clears all bits and suppresses new events in that cycle.
- R11: `irq` is high for exactly the cycle after a cycle in which one or more new events occur, and low otherwise.
- R12: `data_valid` equals `port_en` AND `port_on_sense`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Chip reset, asynchronous, active low |
| tick_us | input | 1 | One-cycle microsecond tick |
| port_rst | input | 1 | Port reset strobe |
| on_req | input | 1 | Turn-on request strobe |
| off_req | input | 1 | Turn-off request strobe |
| start_tmo | input | 1 | Startup time limit expired |
| sense_high | input | 1 | Sense pin abnormally high |
| gate_high | input | 1 | Gate pin abnormally high |
| port_on_sense | input | 1 | Port output reads as powered |
| cur_low | input | 1 | Port current below maintain threshold |
| evt_clr | input | 1 | Clear-on-read strobe for the event register |
| port_en | output | 1 | Port enable command |
| gate_pd_weak | output | 1 | Select reduced gate pull-down |
| fet_bad | output | 1 | FET Bad latched |
| evt | output | 3 | Sticky events: bit 0 FET Bad, bit 1 startup, bit 2 disconnect |
| irq | output | 1 | One-cycle new-event pulse |
| data_valid | output | 1 | Readback data valid |

## Verification
A host clear-on-read strobe can land in the same cycle as a newly declared fault. The bench provokes this by timing `evt_clr` to the exact tick that completes the disconnect count. It then checks that the new bit survives while the older bits are cleared. A port reset can also coincide with a FET Bad declaration. Random stimulus produces both collisions repeatedly, and the bench judges every cycle against a requirement-level model of the port state, the event bits and the interrupt.

// File: rtl/poe_sup_pkg.sv
package poe_sup_pkg;
  localparam int EVT_W   = 3;
  localparam int EVT_FB  = 0;
  localparam int EVT_ST  = 1;
  localparam int EVT_DIS = 2;
  typedef logic [EVT_W-1:0] evt_vec_t;
endpackage

// File: rtl/poe_fetbad_filter.sv
module poe_fetbad_filter #(
  parameter int PERSIST = 180
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  input  logic symptom,
  input  logic latched,
  output logic fire
);
  localparam int CW = $clog2(PERSIST + 2);
  localparam logic [CW-1:0] CNT_TOP = CW'(PERSIST);

  logic [CW-1:0] cnt_q, cnt_n;
  logic          cnt_en;

  always_comb begin
    fire   = 1'b0;
    cnt_en = 1'b0;
    cnt_n  = cnt_q;
    if (clr || !symptom || latched) begin
      cnt_en = 1'b1;
      cnt_n  = '0;
    end else if (tick) begin
      cnt_en = 1'b1;
      if (cnt_q == CNT_TOP) begin
        fire  = 1'b1;
        cnt_n = '0;
      end else begin
        cnt_n = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_n;
  end

  // R3
  fire_persist_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> (symptom && $past(symptom)));
  // R6
  glitch_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!symptom) |=> !fire);
endmodule

// File: rtl/poe_disc_timer.sv
module poe_disc_timer #(
  parameter int LIMIT = 400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  input  logic arm,
  input  logic cur_low,
  output logic fire
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q, cnt_n;
  logic          cnt_en;

  always_comb begin
    fire   = 1'b0;
    cnt_en = 1'b0;
    cnt_n  = cnt_q;
    if (clr || !arm || !cur_low) begin
      cnt_en = 1'b1;
      cnt_n  = '0;
    end else if (tick) begin
      cnt_en = 1'b1;
      if (cnt_q == CNT_LAST) begin
        fire  = 1'b1;
        cnt_n = '0;
      end else begin
        cnt_n = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_n;
  end

  // R9
  recover_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cur_low || !arm) |=> !fire || (LIMIT == 1));
  // R8
  disc_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> (arm && cur_low && tick));
endmodule

// File: rtl/poe_fault_events.sv
module poe_fault_events
  import poe_sup_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     port_rst,
  input  logic     evt_clr,
  input  evt_vec_t new_evt,
  output evt_vec_t evt,
  output logic     irq
);
  evt_vec_t evt_n;
  logic     irq_n;

  always_comb begin
    if (port_rst) begin
      evt_n = '0;
      irq_n = 1'b0;
    end else begin
      evt_n = (evt_clr ? '0 : evt) | new_evt;
      irq_n = |new_evt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt <= '0;
      irq <= 1'b0;
    end else begin
      evt <= evt_n;
      irq <= irq_n;
    end
  end

  // R10
  evt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt_clr && !port_rst) |=> ((evt & $past(evt)) == $past(evt)));
  // R11
  irq_new_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(evt & ~$past(evt))) |-> irq);
endmodule

// File: rtl/poe_port_supervisor.sv
module poe_port_supervisor
  import poe_sup_pkg::*;
#(
  parameter int PERSIST = 180,
  parameter int LIMIT   = 400
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_us,
  input  logic       port_rst,
  input  logic       on_req,
  input  logic       off_req,
  input  logic       start_tmo,
  input  logic       sense_high,
  input  logic       gate_high,
  input  logic       port_on_sense,
  input  logic       cur_low,
  input  logic       evt_clr,
  output logic       port_en,
  output logic       gate_pd_weak,
  output logic       fet_bad,
  output logic [2:0] evt,
  output logic       irq,
  output logic       data_valid
);
  logic [1:0] rs_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  logic     symptom, fb_fire, st_fire, dis_fire, arm;
  logic     port_en_n, fet_bad_n;
  evt_vec_t new_evt, evt_q;

  assign symptom = sense_high || gate_high || (port_on_sense && !port_en);
  assign arm     = port_en && port_on_sense;
  assign st_fire = !port_rst && port_en && start_tmo && !port_on_sense;

  poe_fetbad_filter #(.PERSIST(PERSIST)) u_fb (
    .clk(clk), .rst_n(rst_i_n), .clr(port_rst), .tick(tick_us),
    .symptom(symptom), .latched(fet_bad), .fire(fb_fire)
  );

  poe_disc_timer #(.LIMIT(LIMIT)) u_dis (
    .clk(clk), .rst_n(rst_i_n), .clr(port_rst), .tick(tick_us),
    .arm(arm), .cur_low(cur_low), .fire(dis_fire)
  );

  always_comb begin
    new_evt          = '0;
    new_evt[EVT_FB]  = fb_fire;
    new_evt[EVT_ST]  = st_fire;
    new_evt[EVT_DIS] = dis_fire && !port_rst;
  end

  poe_fault_events u_evt (
    .clk(clk), .rst_n(rst_i_n), .port_rst(port_rst), .evt_clr(evt_clr),
    .new_evt(new_evt), .evt(evt_q), .irq(irq)
  );
  assign evt = evt_q;

  always_comb begin
    fet_bad_n = port_rst ? 1'b0 : (fet_bad || fb_fire);
    port_en_n = port_en;
    if (port_rst || fet_bad || fb_fire)  port_en_n = 1'b0;
    else if (dis_fire || st_fire)        port_en_n = 1'b0;
    else if (off_req)                    port_en_n = 1'b0;
    else if (on_req)                     port_en_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      port_en <= 1'b0;
      fet_bad <= 1'b0;
    end else begin
      port_en <= port_en_n;
      fet_bad <= fet_bad_n;
    end
  end

  assign gate_pd_weak = fet_bad;
  assign data_valid   = port_en && port_on_sense;

  // R4
  fb_port_off_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    fet_bad |-> !port_en);
  // R5
  fb_sticky_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (fet_bad && !port_rst) |=> fet_bad);
  // R7
  start_off_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    st_fire |=> (!port_en && evt[EVT_ST]));
  // R8
  dis_off_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (dis_fire && !port_rst) |=> (!port_en && evt[EVT_DIS]));
endmodule

// File: tb/poe_port_supervisor_tb.sv
`timescale 1ns/1ps
module poe_port_supervisor_tb_top;
  localparam int P = 20;
  localparam int L = 30;

  logic clk = 1'b0;
  logic rst_n;
  logic tick_us, port_rst, on_req, off_req, start_tmo;
  logic sense_high, gate_high, port_on_sense, cur_low, evt_clr;
  logic port_en, gate_pd_weak, fet_bad, irq, data_valid;
  logic [2:0] evt;

  always #4 clk = ~clk;

  poe_port_supervisor #(.PERSIST(P), .LIMIT(L)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .port_rst(port_rst),
    .on_req(on_req), .off_req(off_req), .start_tmo(start_tmo),
    .sense_high(sense_high), .gate_high(gate_high),
    .port_on_sense(port_on_sense), .cur_low(cur_low), .evt_clr(evt_clr),
    .port_en(port_en), .gate_pd_weak(gate_pd_weak), .fet_bad(fet_bad),
    .evt(evt), .irq(irq), .data_valid(data_valid)
  );

  int n_run = 0, n_fail = 0;
  bit done = 0;

  // requirement-level model state
  int m_fc, m_dc;
  bit m_en, m_fb, m_irq;
  bit [2:0] m_evt;

  task automatic check(bit ok, string req, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit sym_f();
    return sense_high || gate_high || (port_on_sense && !m_en);
  endfunction

  task automatic model_reset();
    m_fc = 0; m_dc = 0; m_en = 0; m_fb = 0; m_irq = 0; m_evt = 0;
  endtask

  task automatic model_update();
    bit s, fbf, stf, dsf;
    bit [2:0] nw;
    s   = sym_f();
    fbf = tick_us && s && !m_fb && !port_rst && (m_fc == P);
    stf = !port_rst && m_en && start_tmo && !port_on_sense;
    dsf = !port_rst && m_en && port_on_sense && cur_low && tick_us && (m_dc == L-1);
    if (port_rst || !s || m_fb) m_fc = 0;
    else if (tick_us) m_fc = (m_fc == P) ? 0 : m_fc + 1;
    if (port_rst || !(m_en && port_on_sense) || !cur_low) m_dc = 0;
    else if (tick_us) m_dc = (m_dc == L-1) ? 0 : m_dc + 1;
    nw = port_rst ? 3'b000 : {dsf, stf, fbf};
    m_irq = |nw;
    m_evt = port_rst ? 3'b000 : ((evt_clr ? 3'b000 : m_evt) | nw);
    if (port_rst || m_fb || fbf || dsf || stf || off_req) m_en = 0;
    else if (on_req) m_en = 1;
    m_fb = port_rst ? 0 : (m_fb || fbf);
  endtask

  task automatic compare();
    check(port_en == m_en, "R2 port_en", port_en, m_en);
    check(fet_bad == m_fb, "R3 fet_bad", fet_bad, m_fb);
    check(gate_pd_weak == m_fb, "R4 gate_pd_weak", gate_pd_weak, m_fb);
    check(evt == m_evt, "R10 evt", evt, m_evt);
    check(irq == m_irq, "R11 irq", irq, m_irq);
    check(data_valid == (m_en && port_on_sense), "R12 data_valid",
          data_valid, m_en && port_on_sense);
  endtask

  task automatic idle();
    tick_us = 0; port_rst = 0; on_req = 0; off_req = 0; start_tmo = 0;
    sense_high = 0; gate_high = 0; port_on_sense = 0; cur_low = 0; evt_clr = 0;
  endtask

  // one clock: inputs already driven at negedge
  task automatic step();
    @(posedge clk);
    model_update();
    @(negedge clk);
    compare();
    on_req = 0; off_req = 0; port_rst = 0; evt_clr = 0; start_tmo = 0;
  endtask

  task automatic chip_reset();
    rst_n = 0;
    idle();
    repeat (3) @(negedge clk);
    // R1
    check(port_en == 0 && fet_bad == 0 && evt == 0 && irq == 0 && data_valid == 0
          && gate_pd_weak == 0, "R1 reset state", {port_en, fet_bad, irq}, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    model_reset();
    check(port_en == 0 && evt == 0 && irq == 0, "R1 after release",
          {port_en, evt, irq}, 0);
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    if (!done) $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    chip_reset();

    // R2 turn on / off
    on_req = 1; step();
    check(port_en == 1, "R2 on", port_en, 1);
    port_on_sense = 1; step();
    check(data_valid == 1, "R12 valid when on", data_valid, 1);
    off_req = 1; on_req = 1; step();
    check(port_en == 0, "R2 off wins", port_en, 0);
    check(data_valid == 0, "R12 invalid when off", data_valid, 0);

    // R3/R4: port reads on while commanded off -> symptom
    tick_us = 1;
    for (int i = 0; i < P; i++) step();
    check(fet_bad == 0, "R3 not before P+1", fet_bad, 0);
    step();
    check(fet_bad == 1, "R3 declared", fet_bad, 1);
    check(gate_pd_weak == 1 && evt[0] == 1, "R4 weak pulldown and evt0",
          {gate_pd_weak, evt[0]}, 3);
    check(irq == 1, "R11 irq pulse", irq, 1);
    on_req = 1; step();
    check(port_en == 0, "R4 on_req ignored", port_en, 0);
    check(irq == 0, "R11 irq one cycle", irq, 0);

    // R5 port reset clears, symptom still present -> redeclared
    port_rst = 1; step();
    check(fet_bad == 0 && evt == 0, "R5 port_rst clears", {fet_bad, evt}, 0);
    for (int i = 0; i < P; i++) step();
    check(fet_bad == 0, "R5 not yet redeclared", fet_bad, 0);
    step();
    check(fet_bad == 1, "R5 redeclared", fet_bad, 1);
    rst_n = 0; #1;
    check(fet_bad == 0, "R5 chip reset clears", fet_bad, 1'b0);
    chip_reset();

    // R6 glitch filtering with sense_high
    tick_us = 1; sense_high = 1;
    for (int i = 0; i < P; i++) step();
    sense_high = 0; step();
    sense_high = 1;
    for (int i = 0; i < P; i++) step();
    check(fet_bad == 0, "R6 glitch restarts count", fet_bad, 0);
    step();
    check(fet_bad == 1, "R6 full run declares", fet_bad, 1);
    sense_high = 0; port_rst = 1; step();

    // R7 open FET: startup timeout, never FET Bad
    on_req = 1; step();
    for (int i = 0; i < P + 5; i++) step();
    check(fet_bad == 0 && port_en == 1, "R7 open FET not fet bad", fet_bad, 0);
    start_tmo = 1; step();
    check(port_en == 0 && evt[1] == 1, "R7 startup fault", {port_en, evt[1]}, 1);
    evt_clr = 1; step();
    check(evt == 0, "R10 clear", evt, 0);

    // R8/R9 disconnect, with recovery
    on_req = 1; step();
    port_on_sense = 1; cur_low = 1;
    for (int i = 0; i < L - 1; i++) step();
    cur_low = 0; step();
    cur_low = 1;
    for (int i = 0; i < L - 1; i++) step();
    check(port_en == 1, "R9 recovery restarted timer", port_en, 1);
    evt_clr = 1; step();   // R10: clear coincides with disconnect fire
    check(port_en == 0, "R8 disconnect off", port_en, 0);
    check(evt[2] == 1, "R10 new bit survives clear", evt[2], 1);
    cur_low = 0; port_on_sense = 0; step();

    // random phase
    for (int i = 0; i < 20000; i++) begin
      tick_us       = ($urandom % 4) != 0;
      on_req        = ($urandom % 16) == 0;
      off_req       = ($urandom % 64) == 0;
      port_rst      = ($urandom % 512) == 0;
      evt_clr       = ($urandom % 32) == 0;
      start_tmo     = ($urandom % 40) == 0;
      if (($urandom % 50) == 0) sense_high = ~sense_high;
      if (($urandom % 80) == 0) gate_high = ~gate_high;
      if (($urandom % 10) == 0) port_on_sense = ~port_on_sense;
      if (($urandom % 8) == 0)  cur_low = ~cur_low;
      step();
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 0;
    idle();
  end
endmodule